// File: doc/BRIEF.md
# Two-Wire Bus Start/Stop Watcher with Clock Hold

This block watches the data and clock lines of a two-wire serial bus. It recognises start and stop conditions and records each in a sticky flag that software clears by writing a one. A recognised start makes the block request that the clock line be pulled low. This stretches the bus clock until software has serviced the event. In one mode, a pending counter overflow holds the clock in the same way. The block also reports a collision whenever the bit being driven from the shift register differs from the level sensed on the data line.

Both line inputs pass through a synchronizer chain. The data line then passes through a further short delay line before the start/stop comparison. This delay means that a data change close to a clock fall is judged against a clock level that has already settled. Outside the two-wire modes, the block can instead treat any clock-line edge as a start event, so that the line works as an extra edge interrupt. The start interrupt output is the start flag gated by its enable.

Top module: `twi_bus_watch`

## Requirements
- R1: After reset, start_flag, stop_flag, scl_pull_low and start_irq are all 0.
- R2: With mode = 2'b10 or 2'b11, a falling edge of the data line while the clock line is high sets start_flag. With mode = 2'b00 (outputs off) or 2'b01 (three-wire), such an edge does not set start_flag.
- R3: The data line is delayed by SDA_DELAY cycles (default 2) relative to the clock line before comparison. A data fall that precedes a clock fall by fewer than SDA_DELAY cycles is not a start. A data fall followed by at least SDA_DELAY+2 cycles of clock high is a start.
- R4: start_flag stays set until a cycle in which start_clr is 1 and no new start event occurs. Clearing the flag releases the clock hold that the start caused.
- R5: scl_pull_low is 1 while start_flag is 1, scl_drv_en is 1 and mode[1] is 1. It is 0 when scl_drv_en is 0.
- R6: With mode = 2'b11 and scl_drv_en = 1, scl_pull_low is 1 while ovf_flag is 1. With mode = 2'b10, ovf_flag has no effect on scl_pull_low.
- R7: In a two-wire mode, a rising edge of the data line while the clock line is high sets stop_flag. A stop_clr pulse clears it. A stop has no effect on start_irq, and stop_flag is not set in mode 2'b00.
- R8: In a two-wire mode, collision equals msb XOR the synchronized data line. In modes 2'b00 and 2'b01, collision is 0.
- R9: In mode 2'b00 or 2'b01, with clk_ext = 1 and sw_sel = 0, any edge of the clock line sets start_flag. With sw_sel = 1, clock edges do not set it.
- R10: start_irq is 1 whenever start_flag and start_ie are both 1. Raising start_ie while the flag is already pending raises start_irq at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Raw data line level |
| scl_in | input | 1 | Raw clock line level |
| mode | input | 2 | 00 outputs off, 01 three-wire, 10 two-wire, 11 two-wire with overflow hold |
| clk_ext | input | 1 | Clock source is the external clock line |
| sw_sel | input | 1 | Software clock select bit |
| msb | input | 1 | Shift-register most significant bit being driven |
| ovf_flag | input | 1 | Counter overflow flag |
| start_ie | input | 1 | Start interrupt enable |
| scl_drv_en | input | 1 | Clock line output driver enabled |
| start_clr | input | 1 | Write-one-to-clear strobe for start_flag |
| stop_clr | input | 1 | Write-one-to-clear strobe for stop_flag |
| scl_pull_low | output | 1 | Request to force the clock line low |
| start_flag | output | 1 | Sticky start flag |
| stop_flag | output | 1 | Sticky stop flag |
| collision | output | 1 | Driven bit differs from sensed data line |
| start_irq | output | 1 | Start interrupt |

## Verification
The bench places a data fall one cycle ahead of a clock fall. A design without the data delay would report a false start there. It runs the overflow hold in both two-wire modes, where a design that ignored the mode code would stretch the clock in mode 10. It raises the interrupt enable over an already-pending flag, drives data-line edges in the outputs-off mode, and checks clock edges with the software select bit both set and clear. Randomised rounds mix data bits, starts and clears. They catch a collision flag that leaks outside two-wire mode, and a hold that survives the clearing of the start flag.

// File: rtl/twi_bus_watch.sv
module twi_bus_watch #(
  parameter int SYNC_STAGES = 2,
  parameter int SDA_DELAY   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic [1:0] mode,
  input  logic       clk_ext,
  input  logic       sw_sel,
  input  logic       msb,
  input  logic       ovf_flag,
  input  logic       start_ie,
  input  logic       scl_drv_en,
  input  logic       start_clr,
  input  logic       stop_clr,
  output logic       scl_pull_low,
  output logic       start_flag,
  output logic       stop_flag,
  output logic       collision,
  output logic       start_irq
);

  logic [SYNC_STAGES-1:0] sda_sync, scl_sync;
  logic [SDA_DELAY:0]     sda_dly;
  logic                   scl_q;

  wire sda_s     = sda_sync[SYNC_STAGES-1];
  wire scl_s     = scl_sync[SYNC_STAGES-1];
  wire sda_late  = sda_dly[SDA_DELAY-1];
  wire sda_lateq = sda_dly[SDA_DELAY];
  wire two_wire  = mode[1];

  wire start_evt = two_wire & scl_s & sda_lateq & ~sda_late;
  wire stop_evt  = two_wire & scl_s & ~sda_lateq & sda_late;
  wire edge_evt  = ~two_wire & clk_ext & ~sw_sel & (scl_s ^ scl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sync   <= '1;
      scl_sync   <= '1;
      sda_dly    <= '1;
      scl_q      <= 1'b1;
      start_flag <= 1'b0;
      stop_flag  <= 1'b0;
    end else begin
      sda_sync   <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_sync   <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_dly    <= {sda_dly[SDA_DELAY-1:0], sda_s};
      scl_q      <= scl_s;
      start_flag <= (start_flag & ~start_clr) | start_evt | edge_evt;
      stop_flag  <= (stop_flag & ~stop_clr) | stop_evt;
    end
  end

  assign scl_pull_low = scl_drv_en & two_wire & (start_flag | (mode[0] & ovf_flag));
  assign collision    = two_wire & (msb ^ sda_s);
  assign start_irq    = start_flag & start_ie;

  // R4
  start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_flag && !start_clr) |=> start_flag);

  // R7
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_flag && !stop_clr) |=> stop_flag);

  // R6
  no_ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !start_flag) |-> !scl_pull_low);

  // R8
  collision_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |-> !collision);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_irq |-> start_flag);

  // R2
  no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_flag && mode == 2'b00 && !clk_ext) |=> !start_flag);

endmodule

// File: tb/twi_bus_watch_test.sv
`timescale 1ns/1ps
module twi_bus_watch_test;
  logic clk = 0, rst_n = 0;
  logic sda_in = 1, scl_in = 1, clk_ext = 0, sw_sel = 0, msb = 0, ovf_flag = 0;
  logic start_ie = 0, scl_drv_en = 0, start_clr = 0, stop_clr = 0;
  logic [1:0] mode = 2'b10;
  logic scl_pull_low, start_flag, stop_flag, collision, start_irq;
  int checks = 0, fails = 0;
  bit exp_s;

  always #2.5 clk = ~clk;

  twi_bus_watch uut (.clk, .rst_n, .sda_in, .scl_in, .mode, .clk_ext, .sw_sel, .msb,
    .ovf_flag, .start_ie, .scl_drv_en, .start_clr, .stop_clr, .scl_pull_low,
    .start_flag, .stop_flag, .collision, .start_irq);

  function automatic bit exp_pull(bit [1:0] m, bit en, bit sf, bit ov);
    return en & m[1] & (sf | (m == 2'b11 & ov));
  endfunction
  function automatic bit exp_col(bit [1:0] m, bit b, bit d);
    return m[1] & (b ^ d);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask
  task automatic wait_n(input int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_start_clr; start_clr = 1; wait_n(1); start_clr = 0; wait_n(1); endtask
  task automatic pulse_stop_clr;  stop_clr = 1;  wait_n(1); stop_clr = 0;  wait_n(1); endtask
  task automatic do_start; sda_in = 1; wait_n(6); scl_in = 1; wait_n(6); sda_in = 0; wait_n(8); endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    wait_n(3); rst_n = 1; wait_n(1);
    chk("R1 start_flag", start_flag, 0); chk("R1 stop_flag", stop_flag, 0);
    chk("R1 pull", scl_pull_low, 0);     chk("R1 irq", start_irq, 0);

    // R2 start in two-wire mode 10
    mode = 2'b10; scl_drv_en = 1;
    do_start;
    chk("R2 start set", start_flag, 1);
    chk("R5 pull on start", scl_pull_low, 1);
    scl_drv_en = 0; wait_n(1);
    chk("R5 no pull drv off", scl_pull_low, 0);
    scl_drv_en = 1;
    scl_in = 0; wait_n(6);
    chk("R4 sticky", start_flag, 1);
    pulse_start_clr;
    chk("R4 cleared", start_flag, 0);
    chk("R4 hold released", scl_pull_low, 0);

    // R10 irq immediate when enable raised over pending flag
    do_start; scl_in = 0; wait_n(6);
    chk("R10 irq off", start_irq, 0);
    start_ie = 1; #0.1;
    chk("R10 irq immediate", start_irq, 1);
    pulse_start_clr; start_ie = 0;

    // R3 data fall one cycle before clock fall: no start
    sda_in = 1; wait_n(6); scl_in = 1; wait_n(6);
    sda_in = 0; wait_n(1); scl_in = 0; wait_n(8);
    chk("R3 delayed sda no start", start_flag, 0);

    // R7 stop detect and clear
    scl_in = 1; wait_n(6); sda_in = 1; wait_n(8);
    chk("R7 stop set", stop_flag, 1);
    chk("R7 stop no irq effect", start_flag, 0);
    pulse_stop_clr;
    chk("R7 stop cleared", stop_flag, 0);

    // R2/R7 mode 00: no start, no stop
    mode = 2'b00;
    sda_in = 0; wait_n(8);
    chk("R2 no start in mode 00", start_flag, 0);
    sda_in = 1; wait_n(8);
    chk("R7 no stop in mode 00", stop_flag, 0);

    // R9 clock edge events
    clk_ext = 1; sw_sel = 1; scl_in = 0; wait_n(8);
    chk("R9 sw_sel blocks edge", start_flag, 0);
    sw_sel = 0; scl_in = 1; wait_n(8);
    chk("R9 edge sets flag", start_flag, 1);
    clk_ext = 0; pulse_start_clr;
    chk("R9 cleared", start_flag, 0);

    // R6 overflow hold
    mode = 2'b11; ovf_flag = 1; #0.1;
    chk("R6 ovf hold mode 11", scl_pull_low, 1);
    mode = 2'b10; #0.1;
    chk("R6 no ovf hold mode 10", scl_pull_low, 0);
    ovf_flag = 0; scl_in = 0; wait_n(6);

    // random rounds
    exp_s = 0;
    for (int i = 0; i < 60; i++) begin
      bit d, b, en, ov, ie;
      bit [1:0] m;
      m = 2'($urandom); d = 1'($urandom); b = 1'($urandom);
      en = 1'($urandom); ov = 1'($urandom); ie = 1'($urandom);
      mode = m; scl_drv_en = en; ovf_flag = ov; start_ie = ie; msb = b;
      sda_in = d; wait_n(6);
      chk("R8 collision", collision, exp_col(m, b, d));
      if ($urandom % 3 == 0) begin
        do_start; scl_in = 0; wait_n(6);
        if (m[1]) exp_s = 1;
      end
      if ($urandom % 3 == 0) begin
        pulse_start_clr; exp_s = 0;
      end
      chk("R4 start flag", start_flag, exp_s);
      chk("R5 pull", scl_pull_low, exp_pull(m, en, exp_s, ov));
      chk("R10 irq", start_irq, exp_s & ie);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule